// File: doc/BRIEF.md
# Dual-Timer Input Debouncer

This block cleans up a noisy one-bit signal such as a push button or a contact. Two on-delay timers run side by side. The high-side timer counts time-base ticks while the raw input stays at 1, and the low-side timer counts ticks while the raw input stays at 0. Any change of level clears the timer that was watching the old level. When the high-side timer reaches the programmable hold interval, it sets a set/reset latch. When the low-side timer reaches the same interval, it clears the latch. The latch state is the filtered output.

The block works in rounds of one clock each. On each edge it samples the raw input, the tick strobe and the interval. It then computes the new timer counts and the new latch state from those samples and the state registered on the previous edge. The low-side timer's running count is also a block output, so the surrounding logic can see how long the input has been low. The time base is external: a one-cycle `tick` strobe advances the counters. The raw input must already be synchronized to `clk`.

Top module: `dual_timer_debounce`

## Requirements
- R1: During synchronous reset, and on the first edge after it, `clean_out` is 0 and `off_elapsed` is 0.
- R2: While `raw_in` stays 1 and a tick is present on every edge, the high-side count reaches `hold_time` after `hold_time` edges. `clean_out` becomes 1 on the following edge.
- R3: While `raw_in` stays 0 and a tick is present on every edge, `clean_out` becomes 0 one edge after the low-side count reaches `hold_time`.
- R4: A level that lasts fewer edges than the interval requires leaves `clean_out` unchanged. The opposite level then starts its count again from zero.
- R5: `off_elapsed` is 0 after any edge that sampled `raw_in` = 1. It rises by one on each edge that samples `raw_in` = 0 with `tick` = 1, as long as it is below `hold_time`.
- R6: Once a count equals `hold_time`, it holds that value while its level persists. It never exceeds `hold_time`.
- R7: An edge that samples `tick` = 0 leaves both counts unchanged while the level persists. A timer that has already reached the interval still updates the latch without a tick.
- R8: With `hold_time` = 0, `clean_out` equals the `raw_in` value sampled on the previous edge, and `off_elapsed` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base strobe; each sampled 1 advances an active timer by one |
| raw_in | input | 1 | Unfiltered input level, already synchronous to `clk` |
| hold_time | input | TIME_W | Debounce interval, in ticks, shared by both timers |
| clean_out | output | 1 | Filtered level (the latch state) |
| off_elapsed | output | TIME_W | Running count of the low-side timer |

## Verification
The bound checker watches several rules on every cycle:
- the counters clear as soon as their level goes away;
- the counters step by exactly one under a tick;
- the counters freeze at the interval and freeze without a tick;
- the output changes only in the direction of the level sampled one edge earlier;
- the output follows the input with one cycle of lag when the interval is zero.

Some behaviour only the bench's scenarios can show. These include the exact edge on which the output flips after a full interval, and a short glitch that leaves the output alone. They also include a tick-gated run where the latch sets on an edge without a tick, and a reset issued in the middle of a count.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    typedef enum logic [1:0] {
        LATCH_HOLD  = 2'd0,
        LATCH_SET   = 2'd1,
        LATCH_CLEAR = 2'd2
    } latch_op_e;

    // Index of each timer in the timer bank.
    localparam int unsigned TMR_HIGH = 0;
    localparam int unsigned TMR_LOW  = 1;
    localparam int unsigned TMR_NUM  = 2;

endpackage

// File: rtl/on_delay_timer.sv
module on_delay_timer #(
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic [TIME_W-1:0] preset,
    output logic [TIME_W-1:0] elapsed,
    output logic              done
);

    typedef struct packed {
        logic [TIME_W-1:0] count;
    } tmr_state_t;

    tmr_state_t state_d, state_q;
    logic       below_preset;

    assign below_preset = state_q.count < preset;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d.count = '0;
        end else if (tick && below_preset) begin
            state_d.count = state_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign elapsed = state_q.count;
    assign done    = enable && !below_preset;

endmodule

// File: rtl/sr_hold_latch.sv
module sr_hold_latch
    import dbnc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    typedef struct packed {
        logic level;
    } latch_state_t;

    latch_state_t state_d, state_q;
    latch_op_e    op;

    // Set wins when both requests arrive together.
    always_comb begin
        if (set_i) begin
            op = LATCH_SET;
        end else if (clr_i) begin
            op = LATCH_CLEAR;
        end else begin
            op = LATCH_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        case (op)
            LATCH_SET:   state_d.level = 1'b1;
            LATCH_CLEAR: state_d.level = 1'b0;
            default:     state_d.level = state_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.level;

endmodule

// File: rtl/dual_timer_debounce.sv
module dual_timer_debounce
    import dbnc_pkg::*;
#(
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              raw_in,
    input  logic [TIME_W-1:0] hold_time,
    output logic              clean_out,
    output logic [TIME_W-1:0] off_elapsed
);

    logic [TMR_NUM-1:0]             tmr_en;
    logic [TMR_NUM-1:0]             tmr_done;
    logic [TMR_NUM-1:0][TIME_W-1:0] tmr_count;

    assign tmr_en[TMR_HIGH] = raw_in;
    assign tmr_en[TMR_LOW]  = ~raw_in;

    generate
        for (genvar gi = 0; gi < TMR_NUM; gi++) begin : g_tmr
            on_delay_timer #(
                .TIME_W (TIME_W)
            ) u_tmr (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick),
                .enable  (tmr_en[gi]),
                .preset  (hold_time),
                .elapsed (tmr_count[gi]),
                .done    (tmr_done[gi])
            );
        end
    endgenerate

    sr_hold_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (tmr_done[TMR_HIGH]),
        .clr_i (tmr_done[TMR_LOW]),
        .q     (clean_out)
    );

    assign off_elapsed = tmr_count[TMR_LOW];

endmodule

// File: rtl/dual_timer_debounce_chk.sv
module dual_timer_debounce_chk #(
    parameter int unsigned TIME_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              raw_in,
    input logic [TIME_W-1:0] hold_time,
    input logic              clean_out,
    input logic [TIME_W-1:0] off_elapsed,
    input logic [TIME_W-1:0] on_elapsed
);

    // R1: reset clears the output and the visible count
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!clean_out && off_elapsed == '0));

    // R5: a high sample zeroes the low-side count, and a low sample zeroes the high-side count
    a_r5_off_zero_when_high: assert property (@(posedge clk) disable iff (rst)
        raw_in |=> off_elapsed == '0);
    a_r5_on_zero_when_low: assert property (@(posedge clk) disable iff (rst)
        !raw_in |=> on_elapsed == '0);

    // R5: a tick while low and below the interval steps the count by one
    a_r5_off_step: assert property (@(posedge clk) disable iff (rst)
        (!raw_in && tick && off_elapsed < hold_time)
            |=> off_elapsed == $past(off_elapsed) + 1'b1);

    // R2: same stepping rule for the high-side count
    a_r2_on_step: assert property (@(posedge clk) disable iff (rst)
        (raw_in && tick && on_elapsed < hold_time)
            |=> on_elapsed == $past(on_elapsed) + 1'b1);

    // R6: a count at the interval holds while its level persists
    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        (!raw_in && off_elapsed >= hold_time) |=> $stable(off_elapsed));

    // R7: no tick, no advance
    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!raw_in && !tick) |=> $stable(off_elapsed));

    // R2: the output rises only after a high sample
    a_r2_rise_needs_high: assert property (@(posedge clk) disable iff (rst)
        $rose(clean_out) |-> $past(raw_in));

    // R3: the output falls only after a low sample
    a_r3_fall_needs_low: assert property (@(posedge clk) disable iff (rst)
        $fell(clean_out) |-> !$past(raw_in));

    // R8: a zero interval gives a one-cycle follower
    a_r8_zero_interval: assert property (@(posedge clk) disable iff (rst)
        (hold_time == '0) |=> clean_out == $past(raw_in));

endmodule

bind dual_timer_debounce dual_timer_debounce_chk #(
    .TIME_W (TIME_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .raw_in      (raw_in),
    .hold_time   (hold_time),
    .clean_out   (clean_out),
    .off_elapsed (off_elapsed),
    .on_elapsed  (tmr_count[0])
);

// File: tb/sim_dual_timer_debounce.sv
`timescale 1ns/1ps
module sim_dual_timer_debounce;

    localparam int unsigned TIME_W = 16;
    localparam int unsigned NVEC   = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              raw_in = 1'b0;
    logic [TIME_W-1:0] hold_time = '0;
    logic              clean_out;
    logic [TIME_W-1:0] off_elapsed;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_timer_debounce #(.TIME_W(TIME_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .raw_in      (raw_in),
        .hold_time   (hold_time),
        .clean_out   (clean_out),
        .off_elapsed (off_elapsed)
    );

    // {raw, tick, expected clean_out, expected off_elapsed[3:0]}, interval 3.
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_1_0_0001, 7'b0_1_0_0010, 7'b0_1_0_0011, 7'b0_1_0_0011,
        7'b1_1_0_0000, 7'b1_1_0_0000, 7'b1_1_0_0000, 7'b1_1_1_0000,
        7'b0_1_1_0001, 7'b1_1_1_0000, 7'b1_1_1_0000, 7'b1_1_1_0000,
        7'b0_1_1_0001, 7'b0_1_1_0010, 7'b0_1_1_0011, 7'b0_1_0_0011,
        7'b0_0_0_0011, 7'b1_0_0_0000, 7'b1_0_0_0000, 7'b1_1_0_0000,
        7'b1_0_0_0000, 7'b1_1_0_0000, 7'b1_1_0_0000, 7'b1_0_1_0000
    };

    function automatic string out_tag(int idx);
        if (idx >= 16) return "R7";
        if (idx >= 8 && idx <= 11) return "R4";
        if (idx >= 12) return "R3";
        if (idx >= 4) return "R2";
        return "R3";
    endfunction

    function automatic string el_tag(int idx);
        if (idx == 3 || idx == 15) return "R6";
        if (idx >= 16) return "R7";
        return "R5";
    endfunction

    task automatic check(string req, logic [TIME_W-1:0] act, logic [TIME_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        hold_time = 16'd3;
        tick = 1'b1;
        step();
        step();
        // R1: reset state
        check("R1", {15'd0, clean_out}, '0);
        check("R1", off_elapsed, '0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            raw_in = VEC[i][6];
            tick   = VEC[i][5];
            step();
            check(out_tag(i), {15'd0, clean_out}, {15'd0, VEC[i][4]});
            check(el_tag(i), off_elapsed, {12'd0, VEC[i][3:0]});
        end

        // R8: zero interval, one-cycle follower (output is 1 here)
        hold_time = '0;
        tick = 1'b1;
        raw_in = 1'b0;
        step();
        check("R8", {15'd0, clean_out}, '0);
        check("R8", off_elapsed, '0);
        raw_in = 1'b1;
        step();
        check("R8", {15'd0, clean_out}, 16'd1);
        raw_in = 1'b0;
        step();
        check("R8", {15'd0, clean_out}, '0);
        step();
        check("R8", off_elapsed, '0);

        // R1: reset in the middle of a low-side count
        hold_time = 16'd3;
        raw_in = 1'b1;
        for (int k = 0; k < 5; k++) step();
        check("R2", {15'd0, clean_out}, 16'd1);
        raw_in = 1'b0;
        step();
        step();
        check("R5", off_elapsed, 16'd2);
        check("R4", {15'd0, clean_out}, 16'd1);
        rst = 1'b1;
        step();
        check("R1", {15'd0, clean_out}, '0);
        check("R1", off_elapsed, '0);
        rst = 1'b0;
        step();
        check("R5", off_elapsed, 16'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule